// File: doc/BRIEF.md
# Floating-Point Data Class Tester

The block checks a floating-point operand against a 7-bit class-select mask. It answers whether the operand belongs to any selected class (NaN, positive or negative infinity, positive or negative zero, positive or negative denormal). A normal finite value never belongs to a class.

The block has two kinds of operation. A vector operation classifies every lane of a 128-bit operand, either as two double-precision lanes or as four single-precision lanes. Each lane is written back as all ones on a match and all zeros otherwise. A scalar operation classifies one double-precision or one quad-precision value and forms a 4-bit condition code. That code goes both to the condition-register field chosen by a 3-bit index and to the status FPCC field.

A third scalar operation takes a double-precision operand and judges it as a single-precision value. It counts values that are too small for single precision as matching, and it raises the SO bit when the value is not exactly representable in single precision. A caller pulses `start` with the operation code, operand, mask and field index. The results and a one-cycle `done` pulse appear one clock later.

Top module: `fp_class_tester`

## Requirements
- R1: During and after reset, `done`, `vec_result`, `crf_q` and `fpcc` are all zero.
- R2: Mask bit 6 selects NaN. Any NaN matches when that bit is set, whether quiet or signalling and whatever its sign.
- R3: For infinities, mask bit 5 selects the positive one and bit 4 the negative one.
- R4: For zeros, mask bit 3 selects +0 and bit 2 selects -0.
- R5: For denormals (exponent field zero, fraction non-zero), mask bit 1 selects positive and bit 0 negative. A normal finite value never matches.
- R6: Operation code 0 classifies two double lanes: lane i is `operand[64*i+63:64*i]` and its result goes to the same bits of `vec_result`, as all ones on a match and all zeros otherwise.
- R7: Operation code 1 classifies four single lanes: lane i is `operand[32*i+31:32*i]`, and its result is written the same way at those bits.
- R8: Operation code 2 classifies the double at `operand[63:0]`. The code is {LT, GT, EQ, SO} from bit 3 down to bit 0, with LT the sign bit, GT zero, EQ the match and SO zero. The code goes to `fpcc` and to `crf_q[4*sel+3:4*sel]`, and the other fields of `crf_q` keep their values.
- R9: Operation code 3 does the same as code 2 on the full 128-bit quad operand (1 sign bit, 15 exponent bits, 112 fraction bits), using the same mask encoding.
- R10: Operation code 4 classifies the double at `operand[63:0]`. EQ is also set, regardless of the mask, when the biased exponent lies from 1 through 0x380 inclusive.
- R11: In operation code 4, SO is 0 only when the double is exactly representable as a single. That is the case for zeros, infinities, NaNs whose low 29 fraction bits are zero, normals with biased exponent 0x381..0x47E and low 29 fraction bits zero, and values with biased exponent 0x36A..0x380 whose fraction is zero below bit 926 minus the exponent. SO is 1 in every other case, including double denormals.
- R12: `done` pulses for one cycle, one clock after a `start` with a valid code. Vector codes change only `vec_result`, and scalar codes leave `vec_result` unchanged.
- R13: A `start` with operation code 5, 6 or 7 is ignored: no `done`, and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe |
| op | input | 3 | Operation code 0..4 |
| operand | input | 128 | Source operand |
| cls_mask | input | 7 | Class-select mask |
| crf_sel | input | 3 | Condition-register field index |
| done | output | 1 | Result-valid pulse |
| vec_result | output | 128 | Destination register of vector operations |
| crf_q | output | 32 | Eight 4-bit condition-register fields |
| fpcc | output | 4 | Status FPCC field |

## Verification
Every scalar operation writes the condition-register field and the status FPCC field on the same clock edge. The bench issues scalar operations with different field indices and reads `crf_q` and `fpcc` at the same sample, so a field written to the wrong place, or an FPCC that disagrees with it, is exposed. Vector and scalar strobes also follow each other closely, so that each update can be seen leaving the other kind of result untouched.

// File: rtl/fp_class_tester.sv
module fp_class_tester #(
  parameter int CR_FIELDS = 8,
  localparam int SELW = $clog2(CR_FIELDS),
  localparam int CRW = 4 * CR_FIELDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [127:0]     operand,
  input  logic [6:0]       cls_mask,
  input  logic [SELW-1:0]  crf_sel,
  output logic             done,
  output logic [127:0]     vec_result,
  output logic [CRW-1:0]   crf_q,
  output logic [3:0]       fpcc
);

  function automatic logic cls(input logic s, input logic e_ones, input logic e_zero,
                               input logic f_zero, input logic [6:0] m);
    if (e_ones && !f_zero) return m[6];
    if (e_ones)            return s ? m[4] : m[5];
    if (e_zero && f_zero)  return s ? m[2] : m[3];
    if (e_zero)            return s ? m[0] : m[1];
    return 1'b0;
  endfunction

  logic [127:0] vd, vs;

  for (genvar i = 0; i < 2; i++) begin : g_dlane
    wire [63:0] w = operand[64*i +: 64];
    assign vd[64*i +: 64] = {64{cls(w[63], &w[62:52], ~|w[62:52], ~|w[51:0], cls_mask)}};
  end

  for (genvar i = 0; i < 4; i++) begin : g_slane
    wire [31:0] w = operand[32*i +: 32];
    assign vs[32*i +: 32] = {32{cls(w[31], &w[30:23], ~|w[30:23], ~|w[22:0], cls_mask)}};
  end

  wire [10:0] de = operand[62:52];
  wire [51:0] df = operand[51:0];
  wire        d_match = cls(operand[63], &de, ~|de, ~|df, cls_mask);
  wire        q_match = cls(operand[127], &operand[126:112], ~|operand[126:112],
                            ~|operand[111:0], cls_mask);
  wire        tiny = (de != 11'd0) && (de <= 11'h380);

  logic sp_exact;
  always_comb begin
    int k;
    k = 926 - int'(de);
    sp_exact = 1'b0;
    if (de == 11'd0)                          sp_exact = (df == 52'd0);
    else if (de == 11'h7FF)                   sp_exact = (df[28:0] == 29'd0);
    else if (de >= 11'h381 && de <= 11'h47E)  sp_exact = (df[28:0] == 29'd0);
    else if (de >= 11'h36A && de <= 11'h380) begin
      sp_exact = 1'b1;
      for (int b = 0; b < 52; b++)
        if (b < k && df[b]) sp_exact = 1'b0;
    end
  end

  logic [3:0] cc;
  always_comb begin
    case (op)
      3'd3:    cc = {operand[127], 1'b0, q_match, 1'b0};
      3'd4:    cc = {operand[63], 1'b0, d_match | tiny, ~sp_exact};
      default: cc = {operand[63], 1'b0, d_match, 1'b0};
    endcase
  end

  wire op_ok  = (op <= 3'd4);
  wire scalar = (op >= 3'd2) && op_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      vec_result <= '0;
      crf_q      <= '0;
      fpcc       <= '0;
    end else begin
      done <= start && op_ok;
      if (start && op == 3'd0) vec_result <= vd;
      if (start && op == 3'd1) vec_result <= vs;
      if (start && scalar) begin
        crf_q[{crf_sel, 2'b00} +: 4] <= cc;
        fpcc <= cc;
      end
    end
  end

endmodule

// File: rtl/fp_class_tester_chk.sv
module fp_class_tester_chk #(
  parameter int CR_FIELDS = 8,
  localparam int SELW = $clog2(CR_FIELDS),
  localparam int CRW = 4 * CR_FIELDS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       op,
  input logic [SELW-1:0]  crf_sel,
  input logic             done,
  input logic [127:0]     vec_result,
  input logic [CRW-1:0]   crf_q,
  input logic [3:0]       fpcc
);

  logic [SELW+1:0] sel_q;
  always_ff @(posedge clk) sel_q <= {crf_sel, 2'b00};

  logic lanes_ok;
  always_comb begin
    lanes_ok = 1'b1;
    for (int i = 0; i < 4; i++)
      if (vec_result[32*i +: 32] != 32'd0 && vec_result[32*i +: 32] != '1) lanes_ok = 1'b0;
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && op <= 3'd4 |=> done); // R12
  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start && op > 3'd4 |=> !done && $stable(vec_result) && $stable(crf_q) && $stable(fpcc)); // R13
  AST_SCALAR_KEEPS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    start && op >= 3'd2 |=> $stable(vec_result)); // R12
  AST_VECTOR_KEEPS_CR: assert property (@(posedge clk) disable iff (!rst_n)
    start && op <= 3'd1 |=> $stable(crf_q) && $stable(fpcc)); // R12
  AST_FPCC_EQ_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    start && op >= 3'd2 && op <= 3'd4 |=> crf_q[sel_q +: 4] == fpcc); // R8
  AST_GT_ALWAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !fpcc[2]); // R8
  AST_LANES_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    lanes_ok); // R7

endmodule

bind fp_class_tester fp_class_tester_chk #(.CR_FIELDS(CR_FIELDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .crf_sel(crf_sel),
  .done(done), .vec_result(vec_result), .crf_q(crf_q), .fpcc(fpcc)
);

// File: tb/fp_class_tester_bench.sv
`timescale 1ns/1ps
module fp_class_tester_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   op = '0;
  logic [127:0] operand = '0;
  logic [6:0]   cls_mask = '0;
  logic [2:0]   crf_sel = '0;
  logic         done;
  logic [127:0] vec_result;
  logic [31:0]  crf_q;
  logic [3:0]   fpcc;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fp_class_tester u_fp_class_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
    .cls_mask(cls_mask), .crf_sel(crf_sel), .done(done), .vec_result(vec_result),
    .crf_q(crf_q), .fpcc(fpcc)
  );

  localparam logic [127:0] ONES = '1;

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [127:0] v,
                       input logic [6:0] m, input logic [2:0] s);
    @(negedge clk);
    op = o; operand = v; cls_mask = m; crf_sel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0);
    chk("R1 vec", vec_result, 0);
    chk("R1 crf", crf_q, 0);
    chk("R1 fpcc", fpcc, 0);
  endtask

  task automatic t_vec_dp;
    issue(3'd0, {64'hFFF0000000000000, 64'h3FF0000000000000}, 7'h10, 3'd0);
    chk("R12 done vec", done, 1);
    chk("R3 neg inf lane", vec_result, {ONES[63:0], 64'd0});
    issue(3'd0, {64'h7FF8000000000000, 64'h0000000000000001}, 7'h02, 3'd0);
    chk("R5 pos denorm lane", vec_result, {64'd0, ONES[63:0]});
    issue(3'd0, {64'hFFF0000000000001, 64'h0000000000000001}, 7'h40, 3'd0);
    chk("R2 snan lane", vec_result, {ONES[63:0], 64'd0});
    issue(3'd0, {64'h3FF0000000000000, 64'h7FF0000000000000}, 7'h3F, 3'd0);
    chk("R6 pos inf/normal", vec_result, {64'd0, ONES[63:0]});
  endtask

  task automatic t_vec_sp;
    issue(3'd1, {32'h7FC00000, 32'h80000000, 32'h00000001, 32'h3F800000}, 7'h46, 3'd0);
    chk("R7 four lanes", vec_result, {ONES[95:0], 32'd0});
    issue(3'd1, {32'h00000000, 32'h80000000, 32'h80000001, 32'hFF800000}, 7'h09, 3'd0);
    chk("R4 R7 pos zero neg denorm", vec_result, {32'hFFFFFFFF, 32'd0, 32'hFFFFFFFF, 32'd0});
  endtask

  task automatic t_scalar_dp;
    logic [127:0] keep;
    keep = vec_result;
    issue(3'd2, {64'h7FF8000000000000, 64'hFFF0000000000000}, 7'h10, 3'd2);
    chk("R8 fpcc neg inf", fpcc, 4'b1010);
    chk("R8 crf field 2", crf_q, 32'h00000A00);
    chk("R12 vec kept", vec_result, keep);
    issue(3'd2, 128'h0, 7'h04, 3'd5);
    chk("R4 +0 vs neg-zero mask", fpcc, 4'b0000);
    chk("R8 crf field 5", crf_q, 32'h00000A00);
    issue(3'd2, 128'h8000000000000001, 7'h01, 3'd7);
    chk("R5 neg denorm scalar", fpcc, 4'b1010);
    chk("R8 crf field 7", crf_q, 32'hA0000A00);
    issue(3'd2, 128'h3FF0000000000000, 7'h7F, 3'd1);
    chk("R5 normal never", fpcc, 4'b0000);
  endtask

  task automatic t_scalar_qp;
    issue(3'd3, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 7'h04, 3'd0);
    chk("R9 quad -0", fpcc, 4'b1010);
    chk("R9 crf field 0", crf_q, 32'hA0000A0A);
    issue(3'd3, 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 7'h7F, 3'd0);
    chk("R9 quad normal", crf_q, 32'hA0000A00);
    issue(3'd3, 128'h7FFF_8000_0000_0000_0000_0000_0000_0000, 7'h40, 3'd1);
    chk("R9 quad nan", crf_q, 32'hA0000A20);
    issue(3'd3, 128'h0000_0000_0000_0000_0000_0000_0000_0001, 7'h02, 3'd4);
    chk("R9 quad denorm", fpcc, 4'b0010);
  endtask

  task automatic t_scalar_sp;
    issue(3'd4, 128'h3FF0000000000000, 7'h00, 3'd3);
    chk("R11 1.0 exact", fpcc, 4'b0000);
    issue(3'd4, 128'h3FF0000000000001, 7'h00, 3'd3);
    chk("R11 extra bit", fpcc, 4'b0001);
    chk("R8 crf field 3", crf_q[15:12], 4'b0001);
    issue(3'd4, 128'h3800000000000000, 7'h00, 3'd3);
    chk("R10 exp 0x380 match", fpcc, 4'b0010);
    issue(3'd4, 128'h3810000000000000, 7'h00, 3'd3);
    chk("R10 exp 0x381 no match", fpcc, 4'b0000);
    issue(3'd4, 128'hB690000000000000, 7'h00, 3'd3);
    chk("R10 R11 exp 0x369", fpcc, 4'b1011);
    issue(3'd4, 128'h36A0000000000000, 7'h00, 3'd3);
    chk("R11 smallest single", fpcc, 4'b0010);
    issue(3'd4, 128'h3800000000000001, 7'h00, 3'd3);
    chk("R11 lost low bit", fpcc, 4'b0011);
    issue(3'd4, 128'h47F0000000000000, 7'h00, 3'd3);
    chk("R11 overflow", fpcc, 4'b0001);
    issue(3'd4, 128'h47E0000000000000, 7'h00, 3'd3);
    chk("R11 2^127", fpcc, 4'b0000);
    issue(3'd4, 128'h7FF0000000000001, 7'h40, 3'd3);
    chk("R2 R11 snan", fpcc, 4'b0011);
    issue(3'd4, 128'h0000000000000001, 7'h02, 3'd3);
    chk("R11 double denorm", fpcc, 4'b0011);
  endtask

  task automatic t_ignored;
    logic [127:0] v; logic [31:0] c; logic [3:0] f;
    v = vec_result; c = crf_q; f = fpcc;
    for (int o = 5; o < 8; o++) begin
      issue(3'(o), {64'hFFF0000000000000, 64'hFFF0000000000000}, 7'h7F, 3'd6);
      chk("R13 no done", done, 0);
      chk("R13 vec", vec_result, v);
      chk("R13 crf", crf_q, c);
      chk("R13 fpcc", fpcc, f);
    end
  endtask

  task automatic t_mix;
    logic [31:0] c; logic [3:0] f;
    c = crf_q; f = fpcc;
    issue(3'd1, {4{32'hFF800000}}, 7'h10, 3'd6);
    chk("R12 vec only", vec_result, ONES);
    chk("R12 crf untouched", crf_q, c);
    chk("R12 fpcc untouched", fpcc, f);
    @(negedge clk);
    chk("R12 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_vec_dp();
    t_vec_sp();
    t_scalar_dp();
    t_scalar_qp();
    t_scalar_sp();
    t_ignored();
    t_mix();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule